// File: doc/BRIEF.md
# Two-Dimensional Strided Burst Address Generator

This block walks a rectangular region of memory and turns it into a stream of burst requests for one memory-side port of a DMA engine. A command gives a start address, a row length in bytes, a row count and a row pitch (stride). The pitch may be larger than the row, which leaves a gap between rows. The generator issues each row as a run of contiguous requests, one address and length pair per request, toward a memory master. It raises a one-cycle completion pulse when the last request of the region has been taken.

Commands come in over a valid/ready port. `cmd_ready` is high only while the generator is idle. A command is taken on the cycle where `cmd_valid` and `cmd_ready` are both high. Requests leave over a second valid/ready port. A request counts as acknowledged on the cycle where `req_valid` and `req_ready` are both high. While the master holds `req_ready` low, the request on the port does not change.

In cyclic mode, the region is replayed from its original start as soon as one pass ends, with no new command. A plain `abort` input stops the walk at the next acknowledged request. The address of the request currently on offer can be read at any time on `cur_addr`.

Top module: `dma2d_addr_gen`

## Requirements
- R1: A command is accepted only when `cmd_valid` and `cmd_ready` are high together. `cmd_ready` is high exactly while the generator is idle, and a command offered while it is busy is not taken and has no effect on the request stream.
- R2: Both lengths arrive in count-minus-one form. Each row moves `cmd_xlen_m1`+1 bytes, and the region has `cmd_ylen_m1`+1 rows, so a value of 0 in either field means one.
- R3: The first row starts at the start address. Every later row starts at the previous row's start plus the stride. Within a row, requests are contiguous and in ascending address order.
- R4: Each request carries `req_len_m1` = bytes-1. No request exceeds MAX_BURST bytes or crosses a 4096-byte boundary. Each request is the largest one those two limits and the bytes left in the row allow.
- R5: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_len_m1` hold their values.
- R6: The low log2(BUS_BYTES) bits of the start address and of the stride are treated as zero (BUS_BYTES=8 by default, so the low 3 bits are cleared).
- R7: `done` is high for exactly one cycle, the cycle after the handshake of the final request of a pass.
- R8: With `cmd_cyclic` set, the request after the last one of a pass is the first request of the same region again, with no new command. `done` pulses once per pass.
- R9: An `abort` pulse lets the request on offer finish its handshake. The generator is idle in the cycle after that handshake and gives no `done`. While that request is stalled, it stays on the port.
- R10: `cur_addr` equals the address of the request on offer. After reset it is zero.
- R11: With HAS_2D=0, the row count is ignored and every command moves one row.
- R12: After reset, `cmd_ready` is 1 and `req_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Generator idle, command can be taken |
| cmd_addr | input | ADDR_W | Region start address |
| cmd_xlen_m1 | input | LEN_W | Row length in bytes, minus one |
| cmd_ylen_m1 | input | ROW_W | Row count, minus one |
| cmd_stride | input | ADDR_W | Row pitch in bytes |
| cmd_cyclic | input | 1 | Replay the region until aborted |
| abort | input | 1 | Stop after the current request |
| req_valid | output | 1 | Request on offer |
| req_ready | input | 1 | Master takes the request |
| req_addr | output | ADDR_W | Request start address |
| req_len_m1 | output | log2(MAX_BURST) | Request length in bytes, minus one |
| cur_addr | output | ADDR_W | Address of the request on offer |
| done | output | 1 | One-cycle pulse at the end of each pass |

## Verification
The hardest case to reach is an abort that arrives while a request is stalled, or that coincides with the wrap of a cyclic pass. Only the timing of `req_ready` against `abort` decides which request is the last one. The stimulus handles the first case by holding `req_ready` low, pulsing `abort`, and then releasing the master. It handles the cyclic case by counting `done` pulses and firing `abort` one cycle into the third pass. The 4 KB split is reached with a row that starts 64 bytes below a page boundary, so a single row yields three requests of different sizes.

// File: rtl/dma2d_pkg.sv
`timescale 1ns/1ps
package dma2d_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} walk_st_e;
endpackage

// File: rtl/dma2d_burst_split.sv
`timescale 1ns/1ps
// Picks the size of the next request from the address and the bytes left in the row.
module dma2d_burst_split #(
  parameter int RL_W      = 17,
  parameter int MAX_BURST = 128,
  parameter int PAGE      = 4096
) (
  input  logic [$clog2(PAGE)-1:0]      addr_lo,
  input  logic [RL_W-1:0]              row_left,
  output logic [$clog2(MAX_BURST):0]   chunk,
  output logic [$clog2(MAX_BURST)-1:0] len_m1
);
  localparam int PG_W = $clog2(PAGE);
  localparam int BL_W = $clog2(MAX_BURST);
  localparam logic [PG_W:0] PAGE_V = (PG_W+1)'(PAGE);
  localparam logic [PG_W:0] MB_V   = (PG_W+1)'(MAX_BURST);

  logic [PG_W:0] room;
  logic [PG_W:0] cap;
  logic [RL_W-1:0] pick;

  always_comb begin
    room = PAGE_V - {1'b0, addr_lo};
    cap  = (room > MB_V) ? MB_V : room;
    pick = (row_left < RL_W'(cap)) ? row_left : RL_W'(cap);
    chunk  = pick[BL_W:0];
    len_m1 = BL_W'(pick[BL_W:0] - (BL_W+1)'(1));
  end
endmodule

// File: rtl/dma2d_walker.sv
`timescale 1ns/1ps
// Holds the committed region and steps through rows and requests.
module dma2d_walker
  import dma2d_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int ROW_W     = 12,
  parameter int BUS_BYTES = 8,
  parameter int MAX_BURST = 128,
  parameter int HAS_2D    = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [ADDR_W-1:0]      cmd_addr,
  input  logic [LEN_W-1:0]       cmd_xlen_m1,
  input  logic [ROW_W-1:0]       cmd_ylen_m1,
  input  logic [ADDR_W-1:0]      cmd_stride,
  input  logic                   cmd_cyclic,
  input  logic                   abort,
  input  logic                   req_fire,
  input  logic [$clog2(MAX_BURST):0] chunk,
  output logic                   busy,
  output logic [ADDR_W-1:0]      addr_q,
  output logic [LEN_W:0]         row_left_q,
  output logic                   done_q
);
  localparam int RL_W = LEN_W + 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(BUS_BYTES - 1));

  walk_st_e           st_q;
  logic [ADDR_W-1:0]  start_q, stride_q, row_base_q;
  logic [LEN_W-1:0]   xlen_q;
  logic [ROW_W-1:0]   ylen_q, row_idx_q, y_in;
  logic               cyc_q, abort_pend_q, last_chunk;
  logic [RL_W-1:0]    row_bytes;

  generate
    if (HAS_2D != 0) begin : g_rows
      assign y_in = cmd_ylen_m1;
    end else begin : g_single
      assign y_in = {ROW_W{1'b0}} & cmd_ylen_m1;
    end
  endgenerate

  assign busy       = (st_q == ST_RUN);
  assign last_chunk = (RL_W'(chunk) == row_left_q);
  assign row_bytes  = {1'b0, xlen_q} + RL_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      start_q <= '0; stride_q <= '0; row_base_q <= '0; addr_q <= '0;
      xlen_q <= '0; ylen_q <= '0; row_idx_q <= '0; row_left_q <= '0;
      cyc_q <= 1'b0; abort_pend_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          abort_pend_q <= 1'b0;
          if (cmd_valid) begin
            st_q       <= ST_RUN;
            start_q    <= cmd_addr & ALIGN_MASK;
            row_base_q <= cmd_addr & ALIGN_MASK;
            addr_q     <= cmd_addr & ALIGN_MASK;
            stride_q   <= cmd_stride & ALIGN_MASK;
            xlen_q     <= cmd_xlen_m1;
            ylen_q     <= y_in;
            cyc_q      <= cmd_cyclic;
            row_idx_q  <= '0;
            row_left_q <= {1'b0, cmd_xlen_m1} + RL_W'(1);
          end
        end
        default: begin
          if (req_fire) begin
            if (abort || abort_pend_q) begin
              st_q <= ST_IDLE;
              abort_pend_q <= 1'b0;
            end else if (!last_chunk) begin
              addr_q     <= addr_q + ADDR_W'(chunk);
              row_left_q <= row_left_q - RL_W'(chunk);
            end else if (row_idx_q != ylen_q) begin
              row_idx_q  <= row_idx_q + ROW_W'(1);
              row_base_q <= row_base_q + stride_q;
              addr_q     <= row_base_q + stride_q;
              row_left_q <= row_bytes;
            end else begin
              done_q <= 1'b1;
              if (cyc_q) begin
                row_base_q <= start_q;
                addr_q     <= start_q;
                row_idx_q  <= '0;
                row_left_q <= row_bytes;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end else if (abort) begin
            abort_pend_q <= 1'b1;
          end
        end
      endcase
    end
  end

  // R7
  done_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(req_fire));

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_fire && (abort || abort_pend_q)) |=> (!busy && !done_q));
endmodule

// File: rtl/dma2d_addr_gen.sv
`timescale 1ns/1ps
module dma2d_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int ROW_W     = 12,
  parameter int BUS_BYTES = 8,
  parameter int MAX_BURST = 128,
  parameter int HAS_2D    = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [ADDR_W-1:0]            cmd_addr,
  input  logic [LEN_W-1:0]             cmd_xlen_m1,
  input  logic [ROW_W-1:0]             cmd_ylen_m1,
  input  logic [ADDR_W-1:0]            cmd_stride,
  input  logic                         cmd_cyclic,
  input  logic                         abort,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [ADDR_W-1:0]            req_addr,
  output logic [$clog2(MAX_BURST)-1:0] req_len_m1,
  output logic [ADDR_W-1:0]            cur_addr,
  output logic                         done
);
  localparam int PAGE = 4096;
  localparam int PG_W = $clog2(PAGE);
  localparam int BL_W = $clog2(MAX_BURST);
  localparam int RL_W = LEN_W + 1;

  logic              busy, req_fire;
  logic [ADDR_W-1:0] addr_q;
  logic [RL_W-1:0]   row_left_q;
  logic [BL_W:0]     chunk;

  assign cmd_ready = !busy;
  assign req_valid = busy;
  assign req_addr  = addr_q;
  assign cur_addr  = addr_q;
  assign req_fire  = busy && req_ready;

  dma2d_walker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ROW_W(ROW_W),
    .BUS_BYTES(BUS_BYTES), .MAX_BURST(MAX_BURST), .HAS_2D(HAS_2D)
  ) walker_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_xlen_m1(cmd_xlen_m1),
    .cmd_ylen_m1(cmd_ylen_m1), .cmd_stride(cmd_stride), .cmd_cyclic(cmd_cyclic),
    .abort(abort), .req_fire(req_fire), .chunk(chunk),
    .busy(busy), .addr_q(addr_q), .row_left_q(row_left_q), .done_q(done)
  );

  dma2d_burst_split #(.RL_W(RL_W), .MAX_BURST(MAX_BURST), .PAGE(PAGE)) split_i (
    .addr_lo(addr_q[PG_W-1:0]), .row_left(row_left_q),
    .chunk(chunk), .len_m1(req_len_m1)
  );

  // R5
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len_m1)));

  // R4
  no_page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (({1'b0, req_addr[PG_W-1:0]} + (PG_W+1)'(req_len_m1)) < (PG_W+1)'(PAGE)));

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !req_valid);

  // R1
  busy_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> req_valid);
endmodule

// File: tb/dma2d_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma2d_addr_gen_tb_top;
  localparam int MB = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cmd_valid = 0, cmd_ready, cmd_cyclic = 0, abort = 0;
  logic [31:0] cmd_addr = 0, cmd_stride = 0;
  logic [15:0] cmd_xlen_m1 = 0;
  logic [11:0] cmd_ylen_m1 = 0;
  logic        req_valid, req_ready, done;
  logic [31:0] req_addr, cur_addr;
  logic [6:0]  req_len_m1;

  dma2d_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_xlen_m1(cmd_xlen_m1), .cmd_ylen_m1(cmd_ylen_m1),
    .cmd_stride(cmd_stride), .cmd_cyclic(cmd_cyclic), .abort(abort),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len_m1(req_len_m1), .cur_addr(cur_addr), .done(done));

  logic        d1_valid = 0, d1_cready, d1_rvalid, d1_done;
  logic [31:0] d1_raddr, d1_cur;
  logic [6:0]  d1_rlen;
  dma2d_addr_gen #(.HAS_2D(0)) dut1d_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(d1_valid), .cmd_ready(d1_cready),
    .cmd_addr(32'h100), .cmd_xlen_m1(16'd15), .cmd_ylen_m1(12'd3),
    .cmd_stride(32'h40), .cmd_cyclic(1'b0), .abort(1'b0),
    .req_valid(d1_rvalid), .req_ready(1'b1), .req_addr(d1_raddr),
    .req_len_m1(d1_rlen), .cur_addr(d1_cur), .done(d1_done));

  int checks = 0, errors = 0, done_cnt = 0, exp_done = 0, hs_cnt = 0;
  int d1_hs = 0, d1_dn = 0, rdy_mode = 1;
  bit finished = 0;
  string tag = "R3";
  logic [31:0] q_addr[$];
  int          q_len[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Expected request list: rows at start+k*stride, split at MB and 4 KB.
  task automatic model(input logic [31:0] a0, input int x_m1, input int y_m1,
                       input logic [31:0] s);
    logic [31:0] row;
    row = a0 & ~32'h7;
    for (int r = 0; r <= y_m1; r++) begin
      logic [31:0] a;
      int left;
      a = row; left = x_m1 + 1;
      while (left > 0) begin
        int room, c;
        room = 4096 - int'(a[11:0]);
        c = (room < MB) ? room : MB;
        if (left < c) c = left;
        q_addr.push_back(a); q_len.push_back(c - 1);
        a += 32'(c); left -= c;
      end
      row += s & ~32'h7;
    end
  endtask

  task automatic run_cmd(input logic [31:0] a, input int x_m1, input int y_m1,
                         input logic [31:0] s, input bit cyc, input int passes);
    for (int p = 0; p < passes; p++) model(a, x_m1, y_m1, s);
    chk(cmd_ready === 1'b1, "R1", "ready before command", cmd_ready, 1);
    cmd_addr = a; cmd_xlen_m1 = 16'(x_m1); cmd_ylen_m1 = 12'(y_m1);
    cmd_stride = s; cmd_cyclic = cyc; cmd_valid = 1;
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 5000; i++) begin
      if (q_addr.size() == 0 && cmd_ready) break;
      @(posedge clk);
    end
    repeat (2) @(posedge clk);
    #1;
    chk(q_addr.size() == 0, tag, "requests left", q_addr.size(), 0);
    chk(done_cnt == exp_done, "R7", "done pulses", done_cnt, exp_done);
  endtask

  initial begin
    req_ready = 0;
    forever begin
      @(posedge clk); #1;
      case (rdy_mode)
        0: req_ready = 0;
        1: req_ready = 1;
        default: req_ready = 1'($urandom % 2);
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (done) done_cnt++;
    if (d1_done) d1_dn++;
    if (d1_rvalid) begin
      d1_hs++;
      chk(d1_raddr == 32'h100 && d1_rlen == 7'd15, "R11", "1D request",
          {d1_raddr, 25'(d1_rlen)}, {32'h100, 25'd15});
    end
    if (req_valid && req_ready) begin
      hs_cnt++;
      if (q_addr.size() == 0) chk(0, tag, "unexpected request", req_addr, 0);
      else begin
        logic [31:0] ea; int el;
        ea = q_addr.pop_front(); el = q_len.pop_front();
        chk(req_addr == ea, tag, "req_addr", req_addr, ea);
        chk(int'(req_len_m1) == el, "R4", "req_len_m1", req_len_m1, el);
        chk(cur_addr == ea, "R10", "cur_addr", cur_addr, ea);
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1200000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    // R12
    chk(cmd_ready === 1 && req_valid === 0 && done === 0, "R12", "reset outputs",
        {cmd_ready, req_valid, done}, 3'b100);
    chk(cur_addr === 0, "R10", "cur_addr after reset", cur_addr, 0);
    rst_n = 1;
    @(posedge clk); #1;

    tag = "R2"; run_cmd(32'h40, 31, 0, 0, 0, 1); exp_done++; wait_idle();
    tag = "R2"; run_cmd(32'h80, 0, 0, 0, 0, 1); exp_done++; wait_idle();
    tag = "R4"; run_cmd(32'hFC0, 299, 0, 0, 0, 1); exp_done++; wait_idle();
    tag = "R3"; run_cmd(32'h2000, 99, 3, 32'h200, 0, 1); exp_done++; wait_idle();
    tag = "R3"; run_cmd(32'h3000, 63, 2, 32'h40, 0, 1); exp_done++; wait_idle();
    tag = "R6"; run_cmd(32'h1003, 23, 1, 32'h205, 0, 1); exp_done++; wait_idle();
    rdy_mode = 2;
    tag = "R5"; run_cmd(32'h7F00, 500, 2, 32'h1000, 0, 1); exp_done++; wait_idle();

    // R1: command offered while busy is ignored
    rdy_mode = 0;
    tag = "R1"; run_cmd(32'h9000, 15, 0, 0, 0, 1); exp_done++;
    cmd_addr = 32'hA000; cmd_valid = 1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk(cmd_ready === 0, "R1", "ready while busy", cmd_ready, 0);
    end
    cmd_valid = 0;
    rdy_mode = 1;
    wait_idle();

    // R9: abort during a stalled request
    rdy_mode = 0;
    tag = "R9"; run_cmd(32'h6000, 255, 0, 0, 0, 1);
    repeat (2) @(posedge clk); #1;
    chk(cur_addr == 32'h6000, "R10", "cur_addr while stalled", cur_addr, 32'h6000);
    abort = 1; @(posedge clk); #1; abort = 0;
    repeat (3) @(posedge clk); #1;
    chk(req_valid === 1 && req_addr == 32'h6000, "R9", "stalled request held",
        req_addr, 32'h6000);
    hs_cnt = 0;
    rdy_mode = 1;
    repeat (4) @(posedge clk); #1;
    chk(hs_cnt == 1, "R9", "handshakes after abort", hs_cnt, 1);
    chk(cmd_ready === 1 && req_valid === 0, "R9", "idle after abort", cmd_ready, 1);
    chk(done_cnt == exp_done, "R9", "no done on abort", done_cnt, exp_done);
    q_addr.delete(); q_len.delete();

    // R8: cyclic replay, stopped by abort in the third pass
    tag = "R8"; run_cmd(32'h5000, 39, 2, 32'h80, 1, 3);
    for (int i = 0; i < 2000 && done_cnt < exp_done + 2; i++) @(posedge clk);
    #1;
    abort = 1; @(posedge clk); #1; abort = 0;
    repeat (4) @(posedge clk); #1;
    chk(done_cnt == exp_done + 2, "R8", "done per pass", done_cnt, exp_done + 2);
    chk(cmd_ready === 1 && req_valid === 0, "R9", "idle after cyclic abort",
        cmd_ready, 1);
    exp_done += 2;
    q_addr.delete(); q_len.delete();

    // R11: single-row build ignores the row count
    d1_valid = 1; @(posedge clk); #1; d1_valid = 0;
    repeat (10) @(posedge clk); #1;
    chk(d1_hs == 1, "R11", "1D request count", d1_hs, 1);
    chk(d1_dn == 1, "R11", "1D done count", d1_dn, 1);

    finish_run();
  end
endmodule